// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block sits beside the execute stage of a five-stage in-order pipeline and decides where each of the two ALU operands comes from. There are three possible sources. The first is the value read from the register file. The second is the result held in the latch after execute, which belongs to the instruction one ahead. The third is the result held in the latch after memory, which belongs to the instruction two ahead. One set of comparators finds a match and steers the operand muxes. A consumer three instructions behind its producer needs no bypass, because the register file writes early in the cycle and reads late.

A value loaded from memory only exists once the memory stage has finished. An instruction that needs that value directly behind the load therefore cannot be served by bypassing. The block catches this case in decode. It holds the program counter and the decode latch for one cycle and sends a bubble into execute. On the next cycle the load has moved to the latch after memory, and the operand is bypassed from there.

The interlock is a two-state machine:
- `ST_FLOW` is the normal state.
- `ST_BUBBLE` is the cycle after a stall was raised.

There are two transitions:
- `T_DETECT` goes from `ST_FLOW` to `ST_BUBBLE` when a load-use hazard is seen.
- `T_RELEASE` goes from `ST_BUBBLE` back to `ST_FLOW` unconditionally.

Top module: `fwd_hazard_unit`

## Requirements
- R1: After reset the interlock is in `ST_FLOW`. With all inputs zero, both operand selects are 00 and `hold_pc`, `hold_dec` and `bubble` are 0.
- R2: When neither downstream stage matches an execute source, that operand's select is 00 (register file).
- R3: Select encoding is 00 = register file, 10 = after-execute latch, 01 = after-memory latch. The value 11 never appears.
- R4: If the after-execute destination equals the operand's source, is nonzero, and its write flag is set, the select is 10.
- R5: If only the after-memory destination matches (nonzero, write flag set), the select is 01.
- R6: If both stages match the same source, the after-execute result wins and the select is 10.
- R7: A stage whose destination is register 0, or whose write flag is clear, is never forwarded from.
- R8: If the decode/execute latch holds a load with a nonzero destination, and that destination equals a decode source whose use flag is set, then `hold_pc`, `hold_dec` and `bubble` are all 1 in that cycle. A stall is only ever raised with the load flag set.
- R9: No stall is raised when the load flag is clear, when the matching source's use flag is clear, or when the load destination is register 0.
- R10: A stall lasts exactly one cycle. In the cycle after a stall (`ST_BUBBLE`) all three stall outputs are 0, whatever the inputs.
- R11: Operands A and B are selected independently, so one cycle can show different selects on the two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_src_a | input | REG_W | Execute-stage source register, operand A |
| ex_src_b | input | REG_W | Execute-stage source register, operand B |
| xm_dst | input | REG_W | Destination in the after-execute latch |
| xm_wen | input | 1 | After-execute instruction writes a register |
| mw_dst | input | REG_W | Destination in the after-memory latch |
| mw_wen | input | 1 | After-memory instruction writes a register |
| dx_dst | input | REG_W | Destination in the decode/execute latch |
| dx_load | input | 1 | Decode/execute latch holds a load |
| dec_src_a | input | REG_W | Decode-stage source A |
| dec_src_b | input | REG_W | Decode-stage source B |
| dec_use_a | input | 1 | Decode instruction reads source A |
| dec_use_b | input | 1 | Decode instruction reads source B |
| sel_a | output | 2 | Operand A mux select |
| sel_b | output | 2 | Operand B mux select |
| hold_pc | output | 1 | Freeze the program counter |
| hold_dec | output | 1 | Freeze the decode latch |
| bubble | output | 1 | Insert a no-op into execute |

## Verification
The assertions assume that the surrounding pipeline honours the stall. In the cycle after a stall, the decode/execute latch therefore carries a bubble. They also assume that the write flags and the load flag are steady for the whole cycle. The stimulus applies each cycle's specifiers on the falling edge and holds them until the next falling edge. It presents a load-use hazard in the cycle right after a stall only on purpose, to show that `ST_BUBBLE` suppresses a second stall. It never exercises any other out-of-order pipeline state.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } opnd_sel_e;

    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } stall_state_e;

endpackage

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick
    import fwd_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] xm_dst,
    input  logic             xm_wen,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wen,
    output opnd_sel_e        sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic xm_hit;
    logic mw_hit;

    // A producer qualifies only when it writes and its target is not the zero register.
    always_comb begin
        xm_hit = xm_wen && (xm_dst != ZERO_REG) && (xm_dst == src);
        mw_hit = mw_wen && (mw_dst != ZERO_REG) && (mw_dst == src);
    end

    // The younger producer wins when both match.
    always_comb begin
        unique case ({xm_hit, mw_hit})
            2'b10, 2'b11: sel = SEL_EXMEM;
            2'b01:        sel = SEL_MEMWB;
            default:      sel = SEL_REGFILE;
        endcase
    end

    p_sel_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_no_zero_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_REGFILE) |-> (src != ZERO_REG));

endmodule

// File: rtl/fwd_load_use_detect.sv
module fwd_load_use_detect #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_W-1:0]            dx_dst,
    input  logic                        dx_load,
    input  logic [N_SRC-1:0][REG_W-1:0] dec_src,
    input  logic [N_SRC-1:0]            dec_use,
    output logic                        hazard
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [N_SRC-1:0] src_hit;
    logic             load_live;

    assign load_live = dx_load && (dx_dst != ZERO_REG);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign src_hit[i] = load_live && dec_use[i] && (dec_src[i] == dx_dst);
    end

    assign hazard = |src_hit;

    p_hazard_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> dx_load);

endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
    import fwd_hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);
    stall_state_e state_q;
    stall_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    // Transitions: T_DETECT (FLOW->BUBBLE), T_RELEASE (BUBBLE->FLOW)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW:   if (hazard) state_d = ST_BUBBLE;
            ST_BUBBLE: state_d = ST_FLOW;
            default:   state_d = ST_FLOW;
        endcase
    end

    // Outputs
    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_FLOW:   stall = hazard;
            ST_BUBBLE: stall = 1'b0;
            default:   stall = 1'b0;
        endcase
    end

    p_single_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] xm_dst,
    input  logic             xm_wen,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wen,
    input  logic [REG_W-1:0] dx_dst,
    input  logic             dx_load,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_use_a,
    input  logic             dec_use_b,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             hold_pc,
    output logic             hold_dec,
    output logic             bubble
);
    localparam int N_OPND = 2;

    logic      [N_OPND-1:0][REG_W-1:0] ex_src;
    logic      [N_OPND-1:0][REG_W-1:0] dec_src;
    logic      [N_OPND-1:0]            dec_use;
    opnd_sel_e                         opnd_sel [N_OPND];
    logic                              hazard;
    logic                              stall;

    assign ex_src  = {ex_src_b, ex_src_a};
    assign dec_src = {dec_src_b, dec_src_a};
    assign dec_use = {dec_use_b, dec_use_a};

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        fwd_operand_pick #(.REG_W(REG_W)) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (ex_src[k]),
            .xm_dst (xm_dst),
            .xm_wen (xm_wen),
            .mw_dst (mw_dst),
            .mw_wen (mw_wen),
            .sel    (opnd_sel[k])
        );
    end

    fwd_load_use_detect #(.REG_W(REG_W), .N_SRC(N_OPND)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .dx_dst  (dx_dst),
        .dx_load (dx_load),
        .dec_src (dec_src),
        .dec_use (dec_use),
        .hazard  (hazard)
    );

    fwd_stall_ctrl u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (hazard),
        .stall  (stall)
    );

    assign sel_a    = opnd_sel[0];
    assign sel_b    = opnd_sel[1];
    assign hold_pc  = stall;
    assign hold_dec = stall;
    assign bubble   = stall;

    p_stall_has_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (dx_load && (dx_dst != '0)));

endmodule

// File: tb/fwd_hazard_unit_tb_top.sv
module fwd_hazard_unit_tb_top;
    localparam int REG_W = 5;

    typedef struct {
        logic [REG_W-1:0] ea, eb, xd, md, dd, da, db;
        logic             xw, mw, dl, ua, ub;
    } stim_t;

    typedef struct {
        logic [1:0] sa, sb;
        logic       st;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [REG_W-1:0] ex_src_a = '0, ex_src_b = '0, xm_dst = '0, mw_dst = '0;
    logic [REG_W-1:0] dx_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic xm_wen = 0, mw_wen = 0, dx_load = 0, dec_use_a = 0, dec_use_b = 0;
    logic [1:0] sel_a, sel_b;
    logic hold_pc, hold_dec, bubble;

    int n_checks = 0;
    int n_fail = 0;
    bit m_bub = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    fwd_hazard_unit #(.REG_W(REG_W)) dut_i (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic stim_t blank();
        stim_t s;
        s.ea = 0; s.eb = 0; s.xd = 0; s.md = 0; s.dd = 0; s.da = 0; s.db = 0;
        s.xw = 0; s.mw = 0; s.dl = 0; s.ua = 0; s.ub = 0;
        return s;
    endfunction

    // Expected select from the requirements: 10 after-execute, 01 after-memory, 00 register file
    function automatic logic [1:0] want_sel(input logic [REG_W-1:0] src, input stim_t s);
        if (s.xw && s.xd != 0 && s.xd == src) return 2'b10;
        if (s.mw && s.md != 0 && s.md == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit want_hz(input stim_t s);
        if (!s.dl || s.dd == 0) return 0;
        return (s.ua && s.da == s.dd) || (s.ub && s.db == s.dd);
    endfunction

    task automatic drive(input stim_t s, input string tag);
        exp_t e;
        @(negedge clk);
        ex_src_a = s.ea; ex_src_b = s.eb; xm_dst = s.xd; xm_wen = s.xw;
        mw_dst = s.md; mw_wen = s.mw; dx_dst = s.dd; dx_load = s.dl;
        dec_src_a = s.da; dec_src_b = s.db; dec_use_a = s.ua; dec_use_b = s.ub;
        e.sa = want_sel(s.ea, s);
        e.sb = want_sel(s.eb, s);
        e.st = !m_bub && want_hz(s);
        e.tag = tag;
        m_bub = e.st;
        exp_q.push_back(e);
    endtask

    // Monitor: sample 3 ns after the falling edge, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(sel_a === e.sa, e.tag, "sel_a", sel_a, e.sa);
                check(sel_b === e.sb, e.tag, "sel_b", sel_b, e.sb);
                check(hold_pc === e.st, e.tag, "hold_pc", hold_pc, e.st);
                check(hold_dec === e.st, e.tag, "hold_dec", hold_dec, e.st);
                check(bubble === e.st, e.tag, "bubble", bubble, e.st);
            end
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        stim_t s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        s = blank(); drive(s, "R1 reset idle");
        s = blank(); s.ea = 3; s.eb = 4; s.xd = 7; s.xw = 1; s.md = 9; s.mw = 1;
        drive(s, "R2 no match");
        s = blank(); s.ea = 5; s.eb = 6; s.xd = 5; s.xw = 1;
        drive(s, "R4 R11 exmem on A");
        s = blank(); s.ea = 2; s.eb = 8; s.md = 8; s.mw = 1;
        drive(s, "R5 R3 memwb on B");
        s = blank(); s.ea = 12; s.eb = 12; s.xd = 12; s.xw = 1; s.md = 12; s.mw = 1;
        drive(s, "R6 both match");
        s = blank(); s.ea = 0; s.eb = 0; s.xd = 0; s.xw = 1; s.md = 0; s.mw = 1;
        drive(s, "R7 zero reg");
        s = blank(); s.ea = 9; s.eb = 9; s.xd = 9; s.xw = 0; s.md = 9; s.mw = 1;
        drive(s, "R7 wen clear falls to memwb");
        s = blank(); s.ea = 9; s.eb = 14; s.xd = 14; s.xw = 1; s.md = 9; s.mw = 1;
        drive(s, "R11 A memwb B exmem");
        s = blank(); s.dd = 10; s.dl = 1; s.da = 10; s.ua = 1;
        drive(s, "R8 load-use A");
        s = blank(); s.dd = 10; s.dl = 1; s.da = 10; s.ua = 1;
        drive(s, "R10 bubble cycle suppresses");
        s = blank(); s.dd = 11; s.dl = 1; s.db = 11; s.ub = 1; s.ea = 11; s.md = 11; s.mw = 1;
        drive(s, "R8 load-use B");
        s = blank(); s.ea = 11; s.md = 11; s.mw = 1;
        drive(s, "R10 release");
        s = blank(); s.dd = 13; s.dl = 1; s.db = 13; s.ub = 0;
        drive(s, "R9 use flag clear");
        s = blank(); s.dd = 13; s.dl = 0; s.da = 13; s.ua = 1;
        drive(s, "R9 not a load");
        s = blank(); s.dd = 0; s.dl = 1; s.da = 0; s.ua = 1;
        drive(s, "R9 load to zero reg");
        s = blank(); s.dd = 4; s.dl = 1; s.da = 4; s.db = 4; s.ua = 1; s.ub = 1;
        drive(s, "R8 both sources");

        @(negedge clk);
        #5;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule